// File: doc/BRIEF.md
# Branch Target Predictor

This block predicts the next fetch address for an instruction fetch unit. Each cycle the fetch stage offers its current fetch address. The block compares that address against a direct-mapped table of remembered branches. Each table slot holds a tag, a target address, a valid bit and a two-bit saturating history. If the slot matches and its history leans toward taken, the block returns the remembered target. In every other case it returns the next sequential address.

A separate resolve port reports branches after they execute. Each report carries the branch address, whether the branch was taken, and where it went. The block uses these reports to train the history of matching slots and to claim a slot for a branch the first time it is taken. A freshly claimed slot starts at the most not-taken end of the history. So a branch has to be taken repeatedly before the block starts predicting it.

A prediction enable input comes from a software control bit and forces sequential prediction when it is low. A one-cycle flush input forgets every stored branch.

Top module: `btb_predictor`

## Requirements
- R1: After reset, and for any fetch address with no matching valid slot, `pred_next` equals `fetch_addr + INSTR_BYTES`.
- R2: When `pred_en` is 1 and the slot selected by `fetch_addr` is valid with a matching tag and history code 2'b10 or 2'b11 (bit 1 set = leaning taken), `pred_next` equals that slot's stored target.
- R3: When the matching slot holds history code 2'b00 (strongly not-taken) or 2'b01 (weakly not-taken), `pred_next` is the sequential address.
- R4: A taken resolve whose address misses in the table writes its slot. The slot becomes valid, takes the branch's tag and target, and gets history 2'b00. This overwrites any other branch held in that slot.
- R5: A not-taken resolve whose address misses leaves the table unchanged.
- R6: A resolve that hits moves the history one step along 00, 01, 10, 11. A taken outcome steps up and a not-taken outcome steps down, and the history holds at either end.
- R7: A taken resolve that hits replaces the stored target with the reported target. A not-taken hit keeps the old target.
- R8: While `pred_en` is 0, `pred_next` is always the sequential address. Resolves still train the table.
- R9: `flush_all` invalidates every slot at the next clock edge. It wins over a resolve in the same cycle.
- R10: A lookup in the same cycle as a resolve to the same slot sees the slot's contents from before that resolve.
- R11: The slot index is address bits [OFS_W+IDX_W-1:OFS_W], where OFS_W = log2(INSTR_BYTES) and IDX_W = log2(ENTRIES). The tag is every other address bit. Two addresses that share an index but differ elsewhere therefore compete for one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, invalidates all slots |
| pred_en | input | 1 | Prediction enable from a control register bit |
| flush_all | input | 1 | Invalidate every slot at the next edge |
| fetch_addr | input | ADDR_W | Current fetch address |
| pred_next | output | ADDR_W | Predicted next fetch address (combinational) |
| rs_valid | input | 1 | A resolved branch is reported this cycle |
| rs_addr | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| rs_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
The bench builds the block with ENTRIES=8, ADDR_W=16 and INSTR_BYTES=4. With these values two addresses only 32 bytes apart collide in one slot, so overwrite and aliasing cases (R4, R11) take just a few cycles. A short address pool used in a random phase then revisits slots often, which drives the history counter into both saturated ends and brings up repeated same-cycle lookup and resolve collisions (R6, R10). These runs are mixed with occasional flushes and toggling of the enable.

// File: rtl/btb_pkg.sv
`timescale 1ns/1ps
package btb_pkg;

   typedef enum logic [1:0] {
      HIST_SNT = 2'b00,
      HIST_WNT = 2'b01,
      HIST_WT  = 2'b10,
      HIST_ST  = 2'b11
   } hist_t;

   // one step of the saturating two-bit history
   function automatic hist_t hist_step(input hist_t h, input logic taken);
      hist_t n;
      case (h)
         HIST_SNT: n = taken ? HIST_WNT : HIST_SNT;
         HIST_WNT: n = taken ? HIST_WT  : HIST_SNT;
         HIST_WT:  n = taken ? HIST_ST  : HIST_WNT;
         default:  n = taken ? HIST_ST  : HIST_WT;
      endcase
      return n;
   endfunction

   function automatic logic hist_leans_taken(input hist_t h);
      return h[1];
   endfunction

endpackage

// File: rtl/btb_addr_split.sv
`timescale 1ns/1ps
module btb_addr_split #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 7,
   parameter int OFS_W  = 2,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);
   // index: bits just above the instruction offset; tag: all remaining bits
   assign idx = addr[OFS_W+IDX_W-1:OFS_W];
   assign tag = {addr[ADDR_W-1:OFS_W+IDX_W], addr[OFS_W-1:0]};
endmodule

// File: rtl/btb_update_ctl.sv
`timescale 1ns/1ps
module btb_update_ctl
   import btb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 25
) (
   input  logic              rs_valid,
   input  logic              rs_taken,
   input  logic [TAG_W-1:0]  rs_tag,
   input  logic [ADDR_W-1:0] rs_target,
   input  logic              ent_valid,
   input  logic [TAG_W-1:0]  ent_tag,
   input  hist_t             ent_hist,
   output logic              wr_en,
   output logic              wr_alloc,
   output logic              wr_tgt_en,
   output logic [TAG_W-1:0]  wr_tag,
   output logic [ADDR_W-1:0] wr_tgt,
   output hist_t             wr_hist
);
   logic hit;

   always_comb begin
      hit       = ent_valid && (ent_tag == rs_tag);
      wr_en     = rs_valid && (hit || rs_taken);
      wr_alloc  = rs_valid && !hit && rs_taken;
      wr_tgt_en = rs_valid && rs_taken;
      wr_tag    = rs_tag;
      wr_tgt    = rs_target;
      wr_hist   = hit ? hist_step(ent_hist, rs_taken) : HIST_SNT;
   end
endmodule

// File: rtl/btb_entry_store.sv
`timescale 1ns/1ps
module btb_entry_store
   import btb_pkg::*;
#(
   parameter int ENTRIES = 128,
   parameter int ADDR_W  = 32,
   parameter int TAG_W   = 25,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   // lookup read port
   input  logic [IDX_W-1:0]  lk_idx,
   output logic              lk_valid,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [ADDR_W-1:0] lk_tgt,
   output hist_t             lk_hist,
   // resolve read port
   input  logic [IDX_W-1:0]  rs_idx,
   output logic              rs_ent_valid,
   output logic [TAG_W-1:0]  rs_ent_tag,
   output hist_t             rs_ent_hist,
   // write port (uses rs_idx)
   input  logic              wr_en,
   input  logic              wr_alloc,
   input  logic              wr_tgt_en,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [ADDR_W-1:0] wr_tgt,
   input  hist_t             wr_hist
);
   logic [ENTRIES-1:0] vld_vec;
   logic [TAG_W-1:0]   tag_arr  [ENTRIES];
   logic [ADDR_W-1:0]  tgt_arr  [ENTRIES];
   hist_t              hist_arr [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic              v_r;
      logic [TAG_W-1:0]  tag_r;
      logic [ADDR_W-1:0] tgt_r;
      hist_t             hist_r;
      logic              sel;

      assign sel = wr_en && (rs_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n || flush)      v_r <= 1'b0;
         else if (sel && wr_alloc) v_r <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            hist_r <= wr_hist;
            if (wr_tgt_en) tgt_r <= wr_tgt;
            if (wr_alloc)  tag_r <= wr_tag;
         end
      end

      assign vld_vec[i]  = v_r;
      assign tag_arr[i]  = tag_r;
      assign tgt_arr[i]  = tgt_r;
      assign hist_arr[i] = hist_r;
   end

   assign lk_valid     = vld_vec[lk_idx];
   assign lk_tag       = tag_arr[lk_idx];
   assign lk_tgt       = tgt_arr[lk_idx];
   assign lk_hist      = hist_arr[lk_idx];
   assign rs_ent_valid = vld_vec[rs_idx];
   assign rs_ent_tag   = tag_arr[rs_idx];
   assign rs_ent_hist  = hist_arr[rs_idx];

   // checker state: what was written last edge
   logic             chk_alloc_q, chk_upd_q;
   logic [IDX_W-1:0] chk_idx_q;
   hist_t            chk_old_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_alloc_q <= 1'b0;
         chk_upd_q   <= 1'b0;
         chk_idx_q   <= '0;
         chk_old_q   <= HIST_SNT;
      end else begin
         chk_alloc_q <= wr_en && wr_alloc && !flush;
         chk_upd_q   <= wr_en && !wr_alloc && !flush;
         chk_idx_q   <= rs_idx;
         chk_old_q   <= rs_ent_hist;
      end
   end

   // R4: a fresh slot is valid and starts strongly not-taken
   a_r4_alloc_snt: assert property (@(posedge clk) disable iff (!rst_n)
      chk_alloc_q |-> (vld_vec[chk_idx_q] && hist_arr[chk_idx_q] == HIST_SNT));

   // R6: a hit moves history at most one step, holding only at the ends
   a_r6_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      chk_upd_q |-> ((hist_arr[chk_idx_q] == chk_old_q &&
                      (chk_old_q == HIST_SNT || chk_old_q == HIST_ST)) ||
                     (chk_old_q != HIST_ST  && hist_arr[chk_idx_q] == chk_old_q + 2'd1) ||
                     (chk_old_q != HIST_SNT && hist_arr[chk_idx_q] == chk_old_q - 2'd1)));

   // R9: flush leaves no valid slot
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_vec == '0));

   // R5: without a write or flush the valid set does not change
   a_r5_quiet_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !flush) |=> $stable(vld_vec));
endmodule

// File: rtl/btb_predictor.sv
`timescale 1ns/1ps
module btb_predictor
   import btb_pkg::*;
#(
   parameter int ENTRIES     = 128,
   parameter int ADDR_W      = 32,
   parameter int INSTR_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_en,
   input  logic              flush_all,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [ADDR_W-1:0] pred_next,
   input  logic              rs_valid,
   input  logic [ADDR_W-1:0] rs_addr,
   input  logic              rs_taken,
   input  logic [ADDR_W-1:0] rs_target
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int OFS_W = $clog2(INSTR_BYTES);
   localparam int TAG_W = ADDR_W - IDX_W;

   // elaboration-time parameter checks
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (INSTR_BYTES < 2 || (1 << OFS_W) != INSTR_BYTES) begin : g_bad_instr
      $error("INSTR_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W + OFS_W) begin : g_bad_addr
      $error("ADDR_W too small for index and offset");
   end

   logic [IDX_W-1:0]  f_idx, r_idx;
   logic [TAG_W-1:0]  f_tag, r_tag;
   logic              lk_valid, re_valid;
   logic [TAG_W-1:0]  lk_tag, re_tag;
   logic [ADDR_W-1:0] lk_tgt;
   hist_t             lk_hist, re_hist;
   logic              wr_en, wr_alloc, wr_tgt_en;
   logic [TAG_W-1:0]  wr_tag;
   logic [ADDR_W-1:0] wr_tgt;
   hist_t             wr_hist;
   logic              lk_hit;
   logic [ADDR_W-1:0] seq_addr;

   btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_fsplit (
      .addr(fetch_addr), .idx(f_idx), .tag(f_tag));

   btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_rsplit (
      .addr(rs_addr), .idx(r_idx), .tag(r_tag));

   btb_entry_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush_all),
      .lk_idx(f_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_tgt(lk_tgt),
      .lk_hist(lk_hist),
      .rs_idx(r_idx), .rs_ent_valid(re_valid), .rs_ent_tag(re_tag),
      .rs_ent_hist(re_hist),
      .wr_en(wr_en), .wr_alloc(wr_alloc), .wr_tgt_en(wr_tgt_en),
      .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_hist(wr_hist));

   btb_update_ctl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_upd (
      .rs_valid(rs_valid), .rs_taken(rs_taken), .rs_tag(r_tag),
      .rs_target(rs_target),
      .ent_valid(re_valid), .ent_tag(re_tag), .ent_hist(re_hist),
      .wr_en(wr_en), .wr_alloc(wr_alloc), .wr_tgt_en(wr_tgt_en),
      .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_hist(wr_hist));

   assign seq_addr  = fetch_addr + ADDR_W'(INSTR_BYTES);
   assign lk_hit    = lk_valid && (lk_tag == f_tag);
   assign pred_next = (pred_en && lk_hit && hist_leans_taken(lk_hist)) ? lk_tgt : seq_addr;

   // R8: disabled prediction always falls through
   a_r8_seq_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_en |-> (pred_next == fetch_addr + ADDR_W'(INSTR_BYTES)));

   // R5: a not-taken miss requests no write
   a_r5_nt_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid && !rs_taken && !(re_valid && re_tag == r_tag)) |-> !wr_en);
endmodule

// File: tb/btb_predictor_test.sv
`timescale 1ns/1ps
module btb_predictor_test;
   localparam int AW = 16;
   localparam int NE = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pred_en = 1'b1, flush_all = 1'b0;
   logic [AW-1:0] fetch_addr = '0, rs_addr = '0, rs_target = '0;
   logic          rs_valid = 1'b0, rs_taken = 1'b0;
   logic [AW-1:0] pred_next;

   always #10 clk = ~clk;

   btb_predictor #(.ENTRIES(NE), .ADDR_W(AW), .INSTR_BYTES(4)) uut (
      .clk(clk), .rst_n(rst_n), .pred_en(pred_en), .flush_all(flush_all),
      .fetch_addr(fetch_addr), .pred_next(pred_next),
      .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
      .rs_target(rs_target));

   // reference table built from the requirements
   logic          m_v   [NE];
   logic [12:0]   m_tag [NE];
   logic [AW-1:0] m_tgt [NE];
   logic [1:0]    m_h   [NE];

   function automatic logic [2:0]  ix(input logic [AW-1:0] a); return a[4:2]; endfunction
   function automatic logic [12:0] tg(input logic [AW-1:0] a); return {a[15:5], a[1:0]}; endfunction

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [AW-1:0] q_exp[$];
   string         q_req[$];
   event          chk_ev;

   task automatic cyc(input logic [AW-1:0] fa, input logic en, input logic fl,
                      input logic rv, input logic [AW-1:0] ra, input logic rt,
                      input logic [AW-1:0] rtg, input string req);
      logic [AW-1:0] e;
      logic [2:0] i;
      @(negedge clk);
      fetch_addr = fa; pred_en = en; flush_all = fl;
      rs_valid = rv; rs_addr = ra; rs_taken = rt; rs_target = rtg;
      i = ix(fa);
      e = (en && m_v[i] && m_tag[i] == tg(fa) && m_h[i][1]) ? m_tgt[i] : fa + 16'd4;
      q_exp.push_back(e); q_req.push_back(req);
      #5 -> chk_ev;
      // reference update at the coming edge
      if (fl) begin
         for (int k = 0; k < NE; k++) m_v[k] = 1'b0;
      end else if (rv) begin
         i = ix(ra);
         if (m_v[i] && m_tag[i] == tg(ra)) begin
            if (rt) begin
               m_h[i] = (m_h[i] == 2'b11) ? 2'b11 : m_h[i] + 2'd1;
               m_tgt[i] = rtg;
            end else begin
               m_h[i] = (m_h[i] == 2'b00) ? 2'b00 : m_h[i] - 2'd1;
            end
         end else if (rt) begin
            m_v[i] = 1'b1; m_tag[i] = tg(ra); m_tgt[i] = rtg; m_h[i] = 2'b00;
         end
      end
   endtask

   // lookup only
   task automatic look(input logic [AW-1:0] fa, input string req);
      cyc(fa, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, req);
   endtask
   // resolve while looking up an unrelated sequential address
   task automatic res(input logic [AW-1:0] ra, input logic rt, input logic [AW-1:0] rtg,
                      input string req);
      cyc(16'hF000, 1'b1, 1'b0, 1'b1, ra, rt, rtg, req);
   endtask

   // monitor: pop and compare
   initial begin
      forever begin
         @(chk_ev);
         if (q_exp.size() != 0) begin
            logic [AW-1:0] e;
            string r;
            e = q_exp.pop_front(); r = q_req.pop_front();
            n_cmp++;
            if (pred_next !== e) begin
               n_bad++;
               $display("FAIL %s: pred_next=%h expected=%h (fetch=%h)", r, pred_next, e, fetch_addr);
            end
         end
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   localparam logic [AW-1:0] A  = 16'h0108;  // index 2
   localparam logic [AW-1:0] B  = 16'h0128;  // index 2, other tag (R11)
   localparam logic [AW-1:0] C  = 16'h0010;  // index 4
   localparam logic [AW-1:0] T1 = 16'h0400;
   localparam logic [AW-1:0] T2 = 16'h0880;

   initial begin
      for (int k = 0; k < NE; k++) begin m_v[k] = 0; m_h[k] = 0; m_tag[k] = 0; m_tgt[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      look(A, "R1 reset empty");
      look(C, "R1 reset empty");
      res(A, 1'b0, T1, "R5 nt miss");
      look(A, "R5 nothing allocated");
      res(A, 1'b1, T1, "R4 allocate");
      look(A, "R4 starts SNT -> seq");
      res(A, 1'b1, T1, "R6 SNT->WNT");
      look(A, "R3 WNT -> seq (R5 no prior alloc)");
      // same-cycle lookup and resolve: old contents seen
      cyc(A, 1'b1, 1'b0, 1'b1, A, 1'b1, T1, "R10 old contents");
      look(A, "R2 WT -> target");
      res(A, 1'b1, T1, "R6 WT->ST");
      res(A, 1'b1, T1, "R6 ST saturate");
      res(A, 1'b0, T2, "R7 nt hit keeps target");
      look(A, "R7 still T1 at WT");
      res(A, 1'b1, T2, "R7 taken refresh");
      look(A, "R7 refreshed target");
      cyc(A, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R8 disabled");
      cyc(A, 1'b0, 1'b0, 1'b1, C, 1'b1, T1, "R8 disabled still trains");
      cyc(C, 1'b0, 1'b0, 1'b1, C, 1'b1, T1, "R8 disabled");
      cyc(C, 1'b0, 1'b0, 1'b1, C, 1'b1, T1, "R8 disabled");
      look(C, "R8 trained while off -> target");
      for (int k = 0; k < 4; k++) res(A, 1'b0, T1, "R6 down to SNT");
      res(A, 1'b1, T1, "R6 SNT->WNT");
      look(A, "R6 low saturate then up -> seq");
      res(B, 1'b1, T2, "R11 alias overwrite");
      look(A, "R11 A evicted");
      look(B, "R4 B fresh SNT");
      res(B, 1'b1, T2, "R6"); res(B, 1'b1, T2, "R6");
      look(B, "R2 B taken");
      look(A | 16'h0001, "R11 offset bits are tag");
      cyc(B, 1'b1, 1'b1, 1'b1, C, 1'b1, T1, "R9 flush cycle");
      look(B, "R9 flushed");
      look(C, "R9 flush beats resolve");
      // random phase
      for (int n = 0; n < 600; n++) begin
         logic [AW-1:0] pool [6];
         logic [AW-1:0] fa, ra, tgt;
         pool[0] = A; pool[1] = B; pool[2] = C; pool[3] = 16'h0230;
         pool[4] = 16'h0250; pool[5] = 16'h1014;
         fa  = pool[$urandom_range(0, 5)];
         ra  = pool[$urandom_range(0, 5)];
         tgt = AW'($urandom_range(0, 16'h3FFF)) << 2;
         cyc(fa, ($urandom_range(0, 9) != 0), ($urandom_range(0, 60) == 0),
             ($urandom_range(0, 3) != 0), ra, ($urandom_range(0, 2) != 0), tgt,
             "R2/R3/R6 random");
      end
      @(negedge clk);
      #8;
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule